// File: doc/BRIEF.md
# System Control Register Bank with Oscillator Configuration Channel

This block is a 4 KB window of 32-bit control registers on a simple register bus. The bus has a select, a write enable, a byte address, write data and read data. It holds two general configuration words, and the low byte of the second one drives eight LED outputs. It also holds read-only identification words that are set by parameters, and a switch word that always reads zero.

An indirect configuration channel reaches a private table of three oscillator frequency words. Software first places a value in the outgoing-data register. It then writes the control word with a function code, a device number, a direction bit and a start bit. The block checks the function/device pair and performs the access in the same clock edge. The result shows in a status word with a DONE flag and an ERROR flag. A successful read lands in the return-data register.

A clock-lock register combines eight external lock flags under a writable mask into a single all-locked bit.

Top module: `sysctl_regs`

## Requirements
- R1: After reset the registers read as follows: control reads 0x0010_0000, status reads 0, return data reads 0, outgoing data reads 0, general config 0 reads 0 and config 1 reads 0. The lock register reads 0xFFFF_0001 when all eight lock inputs are 1.
- R2: General config 0 (offset 0x000) and config 1 (offset 0x004) store all 32 written bits. The LED output always equals config 1 bits [7:0], starting the cycle after the write.
- R3: The switch word (0x00C) always reads zero. Config 4 (0x010), auxiliary ID (0xFF8) and ID (0xFFC) read their parameter values. Writes to any of these four offsets change nothing.
- R4: The control word (0x0A8) keeps only the device field [11:0], the function field [25:20] and the direction bit 30 (1 = write). Bits [19:12], [29:26] and the start bit 31 always read back as 0.
- R5: Every control write clears status (0x0AC). When the written bit 31 is 1, status bit 0 (DONE) reads 1 from the next cycle on. A later control write with bit 31 at 0 returns status to 0.
- R6: A transaction is valid only when the function field is 1 and the device field is below 3. Otherwise status bit 1 (ERROR) is set together with DONE, and the frequency table is unchanged.
- R7: A valid write copies outgoing data (0x0A4) into the frequency entry selected by the device field. A valid read loads that entry into return data (0x0A0). A failed read leaves return data unchanged.
- R8: After reset the three frequency entries hold 50,000,000, 24,576,000 and 25,000,000, as parameters.
- R9: In the lock register (0x100), only bits [31:24] (mask, reset 0xFF) are writable. Bits [23:16] show the lock inputs and bits [15:1] read 0. Bit 0 is 1 when every input whose mask bit is set is 1, so it reads 1 when the mask is zero.
- R10: Reads of unmapped offsets return zero. Writes to unmapped offsets change no register.
- R11: Read data is zero unless select is high and write enable is low. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Access select |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte address in the 4 KB window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from the address |
| lock_in | input | 8 | External per-clock lock flags |
| led_out | output | 8 | LED drive, equal to config 1 bits [7:0] |

## Verification
The assertions take for granted that `sel`, `wr_en`, `addr` and `wdata` are stable and known around each rising edge, and that a write lasts exactly one selected cycle. The bench changes these inputs only on falling edges. It opens each access for a single cycle and returns the bus to idle between accesses. The lock inputs are treated as quasi-static: the bench changes them only while no read is in progress. The lock-flag check therefore compares read data with inputs that are steady.

// File: rtl/sysctl_pkg.sv
// Package: shared constants and the control-word layout for the system
// control register bank. Assumes 32-bit words and a 12-bit byte address.
package sysctl_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 12;
    localparam int IDX_W    = ADDR_W - 2;
    localparam int NUM_FREQ = 3;
    localparam int LOCK_N   = 8;

    // Word indices (byte offset / 4) of the mapped registers
    localparam logic [IDX_W-1:0] IDX_GEN0  = 10'h000;
    localparam logic [IDX_W-1:0] IDX_GEN1  = 10'h001;
    localparam logic [IDX_W-1:0] IDX_SWTCH = 10'h003;
    localparam logic [IDX_W-1:0] IDX_GEN4  = 10'h004;
    localparam logic [IDX_W-1:0] IDX_RTN   = 10'h028;
    localparam logic [IDX_W-1:0] IDX_OUTD  = 10'h029;
    localparam logic [IDX_W-1:0] IDX_CTRL  = 10'h02A;
    localparam logic [IDX_W-1:0] IDX_STAT  = 10'h02B;
    localparam logic [IDX_W-1:0] IDX_LOCK  = 10'h040;
    localparam logic [IDX_W-1:0] IDX_AUXID = 10'h3FE;
    localparam logic [IDX_W-1:0] IDX_IDENT = 10'h3FF;

    localparam logic [DATA_W-1:0] CTRL_KEEP  = 32'h43F0_0FFF;
    localparam logic [DATA_W-1:0] CTRL_RESET = 32'h0010_0000;
    localparam logic [5:0]        FUNC_OSC   = 6'd1;

    // Layout of the control word
    typedef struct packed {
        logic        start;
        logic        dir_wr;
        logic [3:0]  rsv_hi;
        logic [5:0]  func;
        logic [7:0]  rsv_lo;
        logic [11:0] dev;
    } ctrl_word_t;
endpackage

// File: rtl/sysctl_cfg_chan.sv
// Configuration channel: holds the control, status, outgoing and return
// data words plus the oscillator frequency table. A control write with the
// start bit performs the whole transaction at that clock edge.
// Assumes wr_ctrl and wr_outd are single-cycle, mutually exclusive strobes.
module sysctl_cfg_chan
    import sysctl_pkg::*;
#(
    parameter int                                   N_FREQ   = NUM_FREQ,
    parameter logic [N_FREQ-1:0][DATA_W-1:0]        FREQ_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_outd,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] stat_q,
    output logic [DATA_W-1:0] outd_q,
    output logic [DATA_W-1:0] ret_q
);
    ctrl_word_t              req;
    logic                    addr_ok;
    logic                    do_wr;
    logic                    do_rd;
    logic [DATA_W-1:0]       rd_sel;
    logic [N_FREQ-1:0][DATA_W-1:0] freq_q;

    assign req     = ctrl_word_t'(wdata);
    assign addr_ok = (req.func == FUNC_OSC) && (req.dev < 12'(N_FREQ));
    assign do_wr   = wr_ctrl && req.start && req.dir_wr && addr_ok;
    assign do_rd   = wr_ctrl && req.start && !req.dir_wr && addr_ok;

    // Select the table entry addressed by the device field
    always_comb begin
        rd_sel = '0;
        for (int i = 0; i < N_FREQ; i++) begin
            if (req.dev == 12'(i)) rd_sel = freq_q[i];
        end
    end

    // Control word: keep only the defined non-start fields
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= CTRL_RESET;
        else if (wr_ctrl) ctrl_q <= wdata & CTRL_KEEP;
    end

    // Status: cleared by any control write, DONE/ERROR set on start
    always_ff @(posedge clk) begin
        if (!rst_n)       stat_q <= '0;
        else if (wr_ctrl) stat_q <= req.start ? {30'b0, !addr_ok, 1'b1} : '0;
    end

    // Outgoing data register
    always_ff @(posedge clk) begin
        if (!rst_n)       outd_q <= '0;
        else if (wr_outd) outd_q <= wdata;
    end

    // Return data: loaded only by a valid read transaction
    always_ff @(posedge clk) begin
        if (!rst_n)     ret_q <= '0;
        else if (do_rd) ret_q <= rd_sel;
    end

    // One frequency entry per device
    for (genvar g = 0; g < N_FREQ; g++) begin : g_freq
        // Entry g: reset value, overwritten by a valid write to device g
        always_ff @(posedge clk) begin
            if (!rst_n)                            freq_q[g] <= FREQ_RST[g];
            else if (do_wr && req.dev == 12'(g))   freq_q[g] <= outd_q;
        end
    end
endmodule

// File: rtl/sysctl_lock.sv
// Clock-lock status: writable mask over external lock flags; bit 0 is the
// AND of the flags selected by the mask. Assumes lock_in is synchronous.
module sysctl_lock
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lock,
    input  logic [LOCK_N-1:0] mask_in,
    input  logic [LOCK_N-1:0] lock_in,
    output logic [DATA_W-1:0] lock_word
);
    localparam int GAP_W = DATA_W - 2 * LOCK_N - 1;

    logic [LOCK_N-1:0] mask_q;
    logic              all_ok;

    // Mask register, reset to all ones
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '1;
        else if (wr_lock) mask_q <= mask_in;
    end

    // Masked lock aggregation
    assign all_ok    = &(lock_in | ~mask_q);
    assign lock_word = {mask_q, lock_in, {GAP_W{1'b0}}, all_ok};
endmodule

// File: rtl/sysctl_regs.sv
// System control register bank (top). Decodes the register bus, holds the
// two general configuration words, drives the LEDs and multiplexes read
// data. Assumes word accesses; address bits [1:0] are ignored.
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter logic [DATA_W-1:0] GEN4_VAL  = 32'h0000_00A5,
    parameter logic [DATA_W-1:0] AUXID_VAL = 32'h0102_0304,
    parameter logic [DATA_W-1:0] IDENT_VAL = 32'h1357_2468,
    parameter logic [DATA_W-1:0] FREQ0_RST = 32'd50_000_000,
    parameter logic [DATA_W-1:0] FREQ1_RST = 32'd24_576_000,
    parameter logic [DATA_W-1:0] FREQ2_RST = 32'd25_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [LOCK_N-1:0] lock_in,
    output logic [LOCK_N-1:0] led_out
);
    localparam logic [NUM_FREQ-1:0][DATA_W-1:0] FREQ_RST =
        {FREQ2_RST, FREQ1_RST, FREQ0_RST};

    logic [IDX_W-1:0]  idx;
    logic              wr_go;
    logic              rd_go;
    logic [DATA_W-1:0] gen0_q;
    logic [DATA_W-1:0] gen1_q;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] stat_q;
    logic [DATA_W-1:0] outd_q;
    logic [DATA_W-1:0] ret_q;
    logic [DATA_W-1:0] lock_word;
    logic [DATA_W-1:0] rd_mux;

    assign idx   = addr[ADDR_W-1:2];
    assign wr_go = sel && wr_en;
    assign rd_go = sel && !wr_en;

    // General configuration words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen0_q <= '0;
            gen1_q <= '0;
        end else if (wr_go) begin
            if (idx == IDX_GEN0) gen0_q <= wdata;
            if (idx == IDX_GEN1) gen1_q <= wdata;
        end
    end

    assign led_out = gen1_q[LOCK_N-1:0];

    sysctl_cfg_chan #(
        .N_FREQ   (NUM_FREQ),
        .FREQ_RST (FREQ_RST)
    ) u_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (wr_go && idx == IDX_CTRL),
        .wr_outd (wr_go && idx == IDX_OUTD),
        .wdata   (wdata),
        .ctrl_q  (ctrl_q),
        .stat_q  (stat_q),
        .outd_q  (outd_q),
        .ret_q   (ret_q)
    );

    sysctl_lock u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_lock   (wr_go && idx == IDX_LOCK),
        .mask_in   (wdata[DATA_W-1 -: LOCK_N]),
        .lock_in   (lock_in),
        .lock_word (lock_word)
    );

    // Read multiplexer; unmapped offsets and the switch word return zero
    always_comb begin
        case (idx)
            IDX_GEN0:  rd_mux = gen0_q;
            IDX_GEN1:  rd_mux = gen1_q;
            IDX_GEN4:  rd_mux = GEN4_VAL;
            IDX_RTN:   rd_mux = ret_q;
            IDX_OUTD:  rd_mux = outd_q;
            IDX_CTRL:  rd_mux = ctrl_q;
            IDX_STAT:  rd_mux = stat_q;
            IDX_LOCK:  rd_mux = lock_word;
            IDX_AUXID: rd_mux = AUXID_VAL;
            IDX_IDENT: rd_mux = IDENT_VAL;
            default:   rd_mux = '0;
        endcase
    end

    assign rdata = rd_go ? rd_mux : '0;
endmodule

// File: rtl/sysctl_regs_chk.sv
// Checker for sysctl_regs: bus-level and channel-status properties.
// Assumes single-cycle bus writes with inputs stable at each rising edge.
module sysctl_regs_chk
    import sysctl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sel,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [LOCK_N-1:0] lock_in,
    input logic [LOCK_N-1:0] led_out,
    input logic [DATA_W-1:0] stat_q,
    input logic [DATA_W-1:0] ret_q
);
    logic [IDX_W-1:0] c_idx;
    logic             c_wr;
    logic             c_rd;
    logic             c_ctl;
    logic             c_bad;
    logic             c_mapped;

    assign c_idx    = addr[ADDR_W-1:2];
    assign c_wr     = sel && wr_en;
    assign c_rd     = sel && !wr_en;
    assign c_ctl    = c_wr && c_idx == IDX_CTRL;
    assign c_bad    = (wdata[25:20] != 6'd1) || (wdata[11:0] >= 12'd3);
    assign c_mapped = c_idx inside {IDX_GEN0, IDX_GEN1, IDX_GEN4, IDX_RTN,
                                    IDX_OUTD, IDX_CTRL, IDX_STAT, IDX_LOCK,
                                    IDX_AUXID, IDX_IDENT};

    AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (c_ctl && !wdata[31]) |=> (stat_q == '0));   // R5
    AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (c_ctl && wdata[31]) |=> stat_q[0]);           // R5
    AST_ERROR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (c_ctl && wdata[31] && c_bad) |=> stat_q[1]);  // R6
    AST_RTN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (c_ctl && wdata[31] && !wdata[30] && c_bad) |=> $stable(ret_q)); // R7
    AST_LED_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wr && c_idx == IDX_GEN1) |=> (led_out == $past(wdata[7:0]))); // R2
    AST_LOCK_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (c_rd && c_idx == IDX_LOCK) |-> (rdata[23:16] == lock_in)); // R9
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (c_rd && !c_mapped) |-> (rdata == '0));       // R10
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !c_rd |-> (rdata == '0));                     // R11
endmodule

bind sysctl_regs sysctl_regs_chk u_chk (.*);

// File: tb/test_sysctl_regs.sv
// Directed bench for sysctl_regs: one task per scenario.
module test_sysctl_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  lock_in = 8'hFF;
    logic [7:0]  led_out;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 1'b0;

    sysctl_regs i_sysctl_regs (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .lock_in(lock_in), .led_out(led_out)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr_en = 1'b0; wdata = '0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr_en = 1'b0; addr = a;
        #1 d = rdata;
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic expect_rd(input string req, input logic [11:0] a,
                             input logic [31:0] exp);
        logic [31:0] d;
        bus_rd(a, d);
        check(req, d, exp);
    endtask

    // Read a frequency entry through the channel
    task automatic freq_rd(input int dev, output logic [31:0] v);
        bus_wr(12'h0A8, 32'h8010_0000 | dev);
        bus_rd(12'h0A0, v);
    endtask

    task automatic t_reset;
        expect_rd("R1 ctrl", 12'h0A8, 32'h0010_0000);
        expect_rd("R1 stat", 12'h0AC, 32'h0);
        expect_rd("R1 rtn", 12'h0A0, 32'h0);
        expect_rd("R1 outd", 12'h0A4, 32'h0);
        expect_rd("R1 gen0", 12'h000, 32'h0);
        expect_rd("R1 gen1", 12'h004, 32'h0);
        expect_rd("R1 lock", 12'h100, 32'hFFFF_0001);
        check("R1 led", {24'h0, led_out}, 32'h0);
    endtask

    task automatic t_general;
        bus_wr(12'h000, 32'hDEAD_BEEF);
        expect_rd("R2 gen0", 12'h000, 32'hDEAD_BEEF);
        bus_wr(12'h004, 32'h1234_5A3C);
        expect_rd("R2 gen1", 12'h004, 32'h1234_5A3C);
        check("R2 led", {24'h0, led_out}, 32'h3C);
    endtask

    task automatic t_readonly;
        bus_wr(12'h00C, 32'hFFFF_FFFF);
        bus_wr(12'h010, 32'hFFFF_FFFF);
        bus_wr(12'hFF8, 32'hFFFF_FFFF);
        bus_wr(12'hFFC, 32'hFFFF_FFFF);
        expect_rd("R3 switch", 12'h00C, 32'h0);
        expect_rd("R3 gen4", 12'h010, 32'h0000_00A5);
        expect_rd("R3 auxid", 12'hFF8, 32'h0102_0304);
        expect_rd("R3 ident", 12'hFFC, 32'h1357_2468);
    endtask

    task automatic t_ctrl_fields;
        bus_wr(12'h0A8, 32'hFFFF_FFFF);
        expect_rd("R4 ctrl mask", 12'h0A8, 32'h43F0_0FFF);
        expect_rd("R6 err all-ones", 12'h0AC, 32'h3);
        bus_wr(12'h0A8, 32'h0000_0000);
        expect_rd("R5 stat cleared", 12'h0AC, 32'h0);
    endtask

    task automatic t_freq_defaults;
        logic [31:0] v;
        freq_rd(0, v); check("R8 freq0", v, 32'd50_000_000);
        freq_rd(1, v); check("R8 freq1", v, 32'd24_576_000);
        freq_rd(2, v); check("R8 freq2", v, 32'd25_000_000);
        expect_rd("R5 done", 12'h0AC, 32'h1);
    endtask

    task automatic t_valid_write;
        logic [31:0] v;
        bus_wr(12'h0A4, 32'h0ABC_1234);
        bus_wr(12'h0A8, 32'hC010_0001);
        expect_rd("R5 done wr", 12'h0AC, 32'h1);
        freq_rd(1, v); check("R7 wr dev1", v, 32'h0ABC_1234);
        freq_rd(0, v); check("R7 dev0 kept", v, 32'd50_000_000);
    endtask

    task automatic t_bad_access;
        logic [31:0] v;
        bus_wr(12'h0A4, 32'h5555_AAAA);
        bus_wr(12'h0A8, 32'hC010_0003);
        expect_rd("R6 bad dev wr", 12'h0AC, 32'h3);
        bus_wr(12'h0A8, 32'hC020_0002);
        expect_rd("R6 bad func wr", 12'h0AC, 32'h3);
        freq_rd(2, v); check("R6 dev2 kept", v, 32'd25_000_000);
        bus_wr(12'h0A8, 32'h8000_0000);
        expect_rd("R6 bad func rd", 12'h0AC, 32'h3);
        expect_rd("R7 rtn kept", 12'h0A0, 32'd25_000_000);
        bus_wr(12'h0A8, 32'h4010_0001);
        expect_rd("R5 no start clears", 12'h0AC, 32'h0);
        expect_rd("R7 rtn no start", 12'h0A0, 32'd25_000_000);
    endtask

    task automatic t_lock;
        bus_wr(12'h100, 32'h1234_5678);
        expect_rd("R9 mask only", 12'h100, 32'h12FF_0001);
        @(negedge clk) lock_in = 8'hFE;
        bus_wr(12'h100, 32'h0100_0000);
        expect_rd("R9 masked unlocked", 12'h100, 32'h01FE_0000);
        bus_wr(12'h100, 32'h0200_0000);
        expect_rd("R9 unmasked bit", 12'h100, 32'h02FE_0001);
        bus_wr(12'h100, 32'h0);
        expect_rd("R9 zero mask", 12'h100, 32'h00FE_0001);
        @(negedge clk) lock_in = 8'hFF;
    endtask

    task automatic t_unmapped;
        bus_wr(12'h008, 32'hFFFF_FFFF);
        bus_wr(12'h200, 32'hFFFF_FFFF);
        expect_rd("R10 unmapped 0x008", 12'h008, 32'h0);
        expect_rd("R10 unmapped 0x200", 12'h200, 32'h0);
        expect_rd("R10 gen0 kept", 12'h000, 32'hDEAD_BEEF);
        expect_rd("R10 gen1 kept", 12'h004, 32'h1234_5A3C);
    endtask

    task automatic t_bus_rules;
        @(negedge clk);
        addr = 12'h000; sel = 1'b0;
        #1 check("R11 idle zero", rdata, 32'h0);
        expect_rd("R11 low bits ignored", 12'h003, 32'hDEAD_BEEF);
    endtask

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 50000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_general();
        t_readonly();
        t_ctrl_fields();
        t_freq_defaults();
        t_valid_write();
        t_bad_access();
        t_lock();
        t_unmapped();
        t_bus_rules();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule